// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received frame is kept, judging only its 48-bit destination address. The six address bytes arrive one per clock on a valid/ready byte stream, first byte first. While they flow in, the block compares them with a programmed station address, checks whether they are all ones, and runs a bit-serial CRC-32 over them. One cycle after the sixth byte is taken, a single verdict (accept or reject) is offered on a second valid/ready handshake.

Unicast destinations must match the station address exactly. The broadcast address is always kept. Any other group address is hashed: the six top bits of the CRC pick one bit of a 64-bit mask, and that bit gives the verdict. A promiscuous input keeps everything. A looped-back internal test mode refuses every frame from the wire.

Back-pressure: the verdict register holds one result. While it is full and `dec_ready` is low, the first five bytes of the next address may still enter. Only the sixth byte is refused (`in_ready` low) until the pending verdict is taken. A verdict taken in the same cycle as the sixth byte frees the register for the new result.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset `dec_valid` is 0 and `in_ready` is 1.
- R2: An address is six bytes taken on `in_valid && in_ready`. The first byte holds address bits 7:0, byte k holds bits 8k+7:8k, and address bit 0 (bit 0 of the first byte) marks a group address. `dec_valid` rises on the clock edge that takes the sixth byte, so it is seen in the following cycle.
- R3: A destination with bit 0 equal to 0 is accepted only when all 48 bits equal `station_addr`, which uses the same byte layout as R2. `station_addr` must stay stable while the bytes arrive.
- R4: The all-ones address is accepted whatever `hash_mask` holds.
- R5: For any other group address, a CRC register is preset to all ones and shifted once per address bit, in bit order 0 to 47. The feedback is CRC[31] xor the data bit, the register shifts left, and the value 0x04C11DB7 is xored in when the feedback is 1. No final inversion is applied. The index CRC[31:26] (CRC[31] is the index MSB) selects `hash_mask[index]`, and the frame is accepted if and only if that bit is 1.
- R6: With `promisc` = 1, every address is accepted.
- R7: With `loop_en` = 1 and `loop_internal` = 1, every address is rejected, even when `promisc` is set. `loop_internal` alone, with `loop_en` = 0, has no effect. The mode inputs and `hash_mask` are sampled in the cycle of the sixth byte.
- R8: While `dec_valid` = 1 and `dec_ready` = 0, `dec_accept` is held stable. `in_ready` is 0 exactly when the next byte would be a sixth byte in that situation. Raising `dec_ready` in that cycle lets the sixth byte in.
- R9: After a verdict is taken (`dec_valid && dec_ready`), `dec_valid` returns to 0 unless a new sixth byte was taken on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Address byte present |
| in_ready | output | 1 | Block takes the byte this cycle |
| in_byte | input | 8 | Address byte, first byte first |
| dec_valid | output | 1 | Verdict available |
| dec_ready | input | 1 | Consumer takes the verdict |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop |
| station_addr | input | 48 | Programmed unicast address |
| hash_mask | input | 64 | Group hash mask, bit n = bin n |
| promisc | input | 1 | Keep all frames |
| loop_en | input | 1 | Loopback mode enable |
| loop_internal | input | 1 | Internal loopback select |

## Verification
Two functions can land on one clock edge: draining the pending verdict and loading the next verdict from a sixth byte. The bench holds `dec_ready` low across a whole second address, so the sixth byte stalls with the first verdict still displayed. It then raises `dec_ready` while that byte is still offered. It judges the result by checking that `in_ready` went high at once, that the old verdict stayed until that edge, and that the verdict seen in the next cycle is the new address's, chosen to differ from the old one.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;
  localparam logic [31:0] CRC32_POLY = 32'h04C11DB7;

  typedef enum logic [1:0] {
    KIND_UNICAST = 2'd0,
    KIND_BCAST   = 2'd1,
    KIND_HASHED  = 2'd2
  } addr_kind_e;
endpackage

// File: rtl/dfilt_byte_seq.sv
module dfilt_byte_seq #(
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             first,
  output logic             last
);
  assign first = (idx == '0);
  assign last  = (idx == IDX_W'(ADDR_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx <= '0;
    else if (step)
      idx <= last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/dfilt_crc_hash.sv
module dfilt_crc_hash #(
  parameter int          CRC_W     = 32,
  parameter logic [31:0] POLY      = dfilt_pkg::CRC32_POLY,
  parameter int          HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 last,
  input  logic [7:0]           byte_in,
  output logic [HASH_BITS-1:0] hash_idx
);
  logic [CRC_W-1:0] crc_q, crc_d;

  // Bit-serial update, bit 0 of the byte first.
  always_comb begin
    crc_d = crc_q;
    for (int b = 0; b < 8; b++) begin
      if (crc_d[CRC_W-1] ^ byte_in[b])
        crc_d = {crc_d[CRC_W-2:0], 1'b0} ^ POLY[CRC_W-1:0];
      else
        crc_d = {crc_d[CRC_W-2:0], 1'b0};
    end
  end

  assign hash_idx = crc_d[CRC_W-1 -: HASH_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      crc_q <= '1;
    else if (step)
      crc_q <= last ? '1 : crc_d;
  end
endmodule

// File: rtl/dfilt_addr_match.sv
module dfilt_addr_match #(
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int ADDR_W = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              first,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        byte_in,
  input  logic [ADDR_W-1:0] station,
  output dfilt_pkg::addr_kind_e kind,
  output logic              uni_hit
);
  logic grp_q, uni_q, bc_q;
  logic grp_d, uni_d, bc_d;
  logic [7:0] st_byte;

  assign st_byte = station[8*int'(idx) +: 8];
  assign grp_d   = first ? byte_in[0] : grp_q;
  assign uni_d   = (first | uni_q) & (byte_in == st_byte);
  assign bc_d    = (first | bc_q) & (&byte_in);
  assign uni_hit = uni_d;

  always_comb begin
    if (!grp_d)     kind = dfilt_pkg::KIND_UNICAST;
    else if (bc_d)  kind = dfilt_pkg::KIND_BCAST;
    else            kind = dfilt_pkg::KIND_HASHED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= 1'b0;
      uni_q <= 1'b0;
      bc_q  <= 1'b0;
    end else if (step) begin
      grp_q <= grp_d;
      uni_q <= uni_d;
      bc_q  <= bc_d;
    end
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int MASK_W = 1 << HASH_BITS,
  localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_accept,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic [MASK_W-1:0] hash_mask,
  input  logic              promisc,
  input  logic              loop_en,
  input  logic              loop_internal
);
  logic                 take, last_take, first, last, uni_hit, verdict;
  logic [IDX_W-1:0]     idx;
  logic [HASH_BITS-1:0] hash_idx;
  dfilt_pkg::addr_kind_e kind;

  assign in_ready  = !(last && dec_valid && !dec_ready);
  assign take      = in_valid && in_ready;
  assign last_take = take && last;

  dfilt_byte_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(take),
    .idx(idx), .first(first), .last(last)
  );

  dfilt_crc_hash #(.HASH_BITS(HASH_BITS)) u_crc (
    .clk(clk), .rst_n(rst_n), .step(take), .last(last),
    .byte_in(in_byte), .hash_idx(hash_idx)
  );

  dfilt_addr_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
    .clk(clk), .rst_n(rst_n), .step(take), .first(first), .idx(idx),
    .byte_in(in_byte), .station(station_addr),
    .kind(kind), .uni_hit(uni_hit)
  );

  // Loopback block outranks promiscuous, which outranks the address rules.
  always_comb begin
    if (loop_en && loop_internal) verdict = 1'b0;
    else if (promisc)             verdict = 1'b1;
    else begin
      unique case (kind)
        dfilt_pkg::KIND_UNICAST: verdict = uni_hit;
        dfilt_pkg::KIND_BCAST:   verdict = 1'b1;
        default:                 verdict = hash_mask[hash_idx];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else if (last_take) begin
      dec_valid  <= 1'b1;
      dec_accept <= verdict;
    end else if (dec_ready) begin
      dec_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/dfilt_chk.sv
module dfilt_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic dec_valid,
  input logic dec_ready,
  input logic dec_accept,
  input logic load,
  input logic promisc,
  input logic loop_en,
  input logic loop_internal
);
  // R2
  load_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> dec_valid);

  // R8
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_accept));

  // R8
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> dec_valid && !dec_ready);

  // R9
  drain_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_ready && !load |=> !dec_valid);

  // R7
  loop_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && loop_en && loop_internal |=> !dec_accept);

  // R6
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && promisc && !(loop_en && loop_internal) |=> dec_accept);
endmodule

bind dest_addr_filter dfilt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .dec_valid(dec_valid),
  .dec_ready(dec_ready), .dec_accept(dec_accept), .load(last_take),
  .promisc(promisc), .loop_en(loop_en), .loop_internal(loop_internal)
);

// File: tb/tb_dest_addr_filter.sv
module tb_dest_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic        dec_valid;
  logic        dec_ready = 1'b1;
  logic        dec_accept;
  logic [47:0] station_addr = 48'hA5_34_12_CD_B6_02;
  logic [63:0] hash_mask = '0;
  logic        promisc = 1'b0;
  logic        loop_en = 1'b0;
  logic        loop_internal = 1'b0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dest_addr_filter dut (.*);

  function automatic logic [5:0] hash_of(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[31] ^ a[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic expect_of(input logic [47:0] a);
    if (loop_en && loop_internal) return 1'b0;
    if (promisc) return 1'b1;
    if (!a[0]) return a == station_addr;
    if (&a) return 1'b1;
    return hash_mask[hash_of(a)];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic push(input logic [47:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = a[8*k +: 8];
      @(posedge clk);
    end
  endtask

  task automatic run(input string req, input logic [47:0] a);
    logic e = expect_of(a);
    push(a, 6);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, dec_valid, 1'b1);
    chk(req, dec_accept, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, b;
    logic        ea;
    repeat (3) @(negedge clk);
    chk("R1 dec_valid", dec_valid, 1'b0);
    chk("R1 in_ready", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 unicast
    run("R3 exact", station_addr);
    @(negedge clk);
    chk("R9 cleared", dec_valid, 1'b0);
    hash_mask = '1;
    for (int k = 0; k < 6; k++)
      run("R3 byte mismatch", station_addr ^ (48'h80 << (8*k)));
    run("R3 bit1 mismatch", station_addr ^ 48'h2);

    // R4 broadcast
    hash_mask = '0;
    run("R4 broadcast", '1);
    run("R5 near-broadcast", ~48'h0200_0000_0000);

    // R5 sweep over 64 group addresses, one-hot and inverse mask
    for (int k = 0; k < 64; k++) begin
      a = {8'(k * 7 + 3), 8'h00, 8'h5E, 8'h00, 8'(k), 8'h01};
      hash_mask = 64'd1 << hash_of(a);
      run("R5 bin set", a);
      chk("R5 arith accept", dec_accept, 1'b1);
      hash_mask = ~(64'd1 << hash_of(a));
      run("R5 bin clear", a);
      chk("R5 arith reject", dec_accept, 1'b0);
    end

    // R6 promiscuous
    hash_mask = '0;
    promisc = 1'b1;
    run("R6 foreign unicast", 48'h11_22_33_44_55_66);
    run("R6 group", 48'h00_00_00_5E_00_01);
    // R7 loopback
    loop_en = 1'b1; loop_internal = 1'b1;
    run("R7 blocks promisc", '1);
    chk("R7 reject", dec_accept, 1'b0);
    promisc = 1'b0;
    run("R7 blocks station", station_addr);
    loop_internal = 1'b0;
    run("R7 external ok", '1);
    loop_en = 1'b0; loop_internal = 1'b1;
    run("R7 internal alone", station_addr);
    chk("R7 no effect", dec_accept, 1'b1);
    loop_internal = 1'b0;

    // R8 back-pressure with same-cycle drain and load
    a = station_addr;            // accepted
    b = 48'h99_88_77_66_55_44;   // rejected unicast
    ea = expect_of(a);
    @(negedge clk);
    dec_ready = 1'b0;
    run("R8 first", a);
    push(b, 5);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b[47:40];
    #1;
    chk("R8 stall", in_ready, 1'b0);
    chk("R8 old held", dec_accept, ea);
    @(posedge clk);
    @(negedge clk);
    chk("R8 still held", dec_accept, ea);
    chk("R8 still valid", dec_valid, 1'b1);
    dec_ready = 1'b1;
    #1;
    chk("R8 released", in_ready, 1'b1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 new valid", dec_valid, 1'b1);
    chk("R8 new verdict", dec_accept, expect_of(b));
    @(negedge clk);
    chk("R9 drained", dec_valid, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule